// File: doc/BRIEF.md
# Banked History Match Engine

This block keeps a window of recently seen bytes in three byte-wide RAM banks and decides, for each position of a byte stream, whether the next output item of a dictionary compressor is a single literal byte or a back-reference copy. Bytes are written in stream order. Each one carries a position made of a word address and a 2-bit tag, and the tag selects the bank. Because neighbouring positions always sit in different banks, any three consecutive bytes can be read in one cycle, one from each bank, and then put back into stream order using the starting tag.

A request carries the current position, the three bytes found there, an earlier candidate position from an external hash lookup, and the end of valid data as a linear byte count. The engine compares three candidate bytes against the current bytes. If all three agree, it keeps fetching and comparing three-byte groups until a byte differs, 18 bytes have matched, or the data end is reached. It then presents one item with a kind flag, a 4-bit length code, the number of input bytes to advance, and the candidate position. The item is held until the consumer takes it. The position of a byte is 3 × word + tag; tag values 0, 1 and 2 are used.

Top module: `tribank_match_engine`

## Requirements
- R1: While reset is asserted and after it is released, req_ready is 1 and item_valid is 0 until a request is accepted.
- R2: A write with wr_en=1 stores wr_data in the bank chosen by wr_tag (0..2) at address wr_word, so it becomes the byte at position 3×wr_word+wr_tag for every later comparison.
- R3: The first comparison uses req_cur_bytes as the current bytes, with bits [7:0] the byte at the current position, [15:8] the next byte and [23:16] the byte after that. Bytes beyond these three come from the banks.
- R4: A literal is produced when req_cand_valid is 0, when the candidate position is not below the current position, or when req_end minus the current position is less than 3.
- R5: A literal item has item_copy=0, item_len_code=0, item_adv=1 and a zero offset.
- R6: When the first three candidate bytes equal the current bytes, a copy item is produced: item_copy=1, item_adv=L (the match length), item_len_code=L−3, and the offset is the candidate word and tag. Otherwise the item is a literal.
- R7: L is the number of leading positions k for which byte(candidate+k) equals byte(current+k). It is capped at 18 and at req_end minus the current position.
- R8: A request is taken only when req_ready is 1. Exactly one item follows each request, and req_ready stays 0 while that item is pending.
- R9: While item_valid is 1 and item_ready is 0, all item fields stay unchanged.
- R10: Writes to positions at or beyond req_end while a request is in progress do not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_word | input | WORD_AW | Word address of the written byte |
| wr_tag | input | 2 | Bank tag of the written byte (0..2) |
| wr_data | input | 8 | Written byte |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_cur_word | input | WORD_AW | Word part of the current position |
| req_cur_tag | input | 2 | Tag part of the current position |
| req_cur_bytes | input | 24 | Three current bytes, first byte in [7:0] |
| req_cand_valid | input | 1 | Candidate position is meaningful |
| req_cand_word | input | WORD_AW | Word part of the candidate position |
| req_cand_tag | input | 2 | Tag part of the candidate position |
| req_end | input | WORD_AW+2 | Linear count of valid bytes (exclusive end) |
| item_valid | output | 1 | Item available |
| item_ready | input | 1 | Consumer takes the item |
| item_copy | output | 1 | 1 for copy, 0 for literal |
| item_len_code | output | 4 | Copy length minus 3 |
| item_adv | output | 5 | Input bytes covered by the item |
| item_off_word | output | WORD_AW | Copy source word |
| item_off_tag | output | 2 | Copy source tag |

## Verification
On every cycle the assertions check the item encoding: a literal always advances by one with a zero code and offset, and a copy's advance lies between 3 and 18 and equals its code plus three. They also check that a copy never runs past the room left before the data end, that an item is frozen while it is stalled, that an invalid candidate gives a literal on the next cycle, and that no request is taken while an item is pending. The actual match length depends on bank contents, tag reordering across all three starting tags, and the step-by-step extension. Only the bench's scenarios can show these, by comparing each item with a byte-level model of the stream: stops at the first difference, at 18 and at the data end, a first-compare override through req_cur_bytes, and writes beyond the end during a compare.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  // Shortest copy worth emitting and width of the length code.
  localparam int MIN_MATCH = 3;
  localparam int CODE_W    = 4;
  // Longest copy the code can express and the width that holds it.
  localparam int MAX_LEN   = MIN_MATCH + (1 << CODE_W) - 1;
  localparam int LEN_W     = $clog2(MAX_LEN + 1);
  localparam int NBANK     = 3;
  localparam int GRP_W     = 8 * NBANK;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CAND,
    ST_CMP,
    ST_RD_CUR,
    ST_LD_CUR,
    ST_EMIT
  } eng_state_t;
endpackage

// File: rtl/tbm_rst_sync.sv
module tbm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tbm_bank.sv
module tbm_bank #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  // Synchronous read; a same-address write in the same cycle returns the old byte.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tbm_addr_align.sv
module tbm_addr_align #(
  parameter int AW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [AW-1:0]         load_word,
  input  logic                  step,
  input  logic [1:0]            tag,
  output logic [2:0][AW-1:0]    bank_addr
);
  logic [AW-1:0] w_q, w_d;
  logic [AW-1:0] w1_q, w1_d;

  // Word and word+1 are both kept in registers, so the bank address is only a mux.
  always_comb begin
    w_d  = w_q;
    w1_d = w1_q;
    if (load) begin
      w_d  = load_word;
      w1_d = load_word + AW'(1);
    end else if (step) begin
      w_d  = w1_q;
      w1_d = w1_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q  <= '0;
      w1_q <= '0;
    end else begin
      w_q  <= w_d;
      w1_q <= w1_d;
    end
  end

  // A bank below the starting tag holds a byte of the following word.
  for (genvar b = 0; b < 3; b++) begin : g_addr
    assign bank_addr[b] = (2'(b) >= tag) ? w_q : w1_q;
  end
endmodule

// File: rtl/tbm_compare.sv
module tbm_compare (
  input  logic [1:0]       tag,
  input  logic [2:0][7:0]  bank_q,
  input  logic [23:0]      ref_bytes,
  output logic [23:0]      ordered,
  output logic [1:0]       nmatch
);
  logic [2:0] eq;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      ordered[8*i +: 8] = bank_q[(int'(tag) + i) % 3];
      eq[i] = (ordered[8*i +: 8] == ref_bytes[8*i +: 8]);
    end
    if (!eq[0])      nmatch = 2'd0;
    else if (!eq[1]) nmatch = 2'd1;
    else if (!eq[2]) nmatch = 2'd2;
    else             nmatch = 2'd3;
  end
endmodule

// File: rtl/tribank_match_engine.sv
module tribank_match_engine
  import tbm_pkg::*;
#(
  parameter int WORD_AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [WORD_AW-1:0]   wr_word,
  input  logic [1:0]           wr_tag,
  input  logic [7:0]           wr_data,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [WORD_AW-1:0]   req_cur_word,
  input  logic [1:0]           req_cur_tag,
  input  logic [23:0]          req_cur_bytes,
  input  logic                 req_cand_valid,
  input  logic [WORD_AW-1:0]   req_cand_word,
  input  logic [1:0]           req_cand_tag,
  input  logic [WORD_AW+1:0]   req_end,
  output logic                 item_valid,
  input  logic                 item_ready,
  output logic                 item_copy,
  output logic [CODE_W-1:0]    item_len_code,
  output logic [LEN_W-1:0]     item_adv,
  output logic [WORD_AW-1:0]   item_off_word,
  output logic [1:0]           item_off_tag
);
  localparam int LIN_W = WORD_AW + 2;

  logic rst_i_n;
  tbm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  eng_state_t           state_q, state_d;
  logic [1:0]           cur_tag_q, cur_tag_d;
  logic [1:0]           cand_tag_q, cand_tag_d;
  logic [WORD_AW-1:0]   cand_word_q, cand_word_d;
  logic [23:0]          ref_q, ref_d;
  logic [LEN_W-1:0]     lim_q, lim_d;
  logic                 copy_q, copy_d;
  logic [LEN_W-1:0]     len_q;
  logic                 len_clr, len_inc_en;
  logic [LEN_W-1:0]     len_inc;
  logic                 step_s, accept;

  // Linear positions of the request.
  logic [LIN_W-1:0] cur_lin, cand_lin, avail;
  logic             early_lit;
  logic [LEN_W-1:0] lim_calc;

  always_comb begin
    cur_lin   = (LIN_W'(req_cur_word) << 1) + LIN_W'(req_cur_word) + LIN_W'(req_cur_tag);
    cand_lin  = (LIN_W'(req_cand_word) << 1) + LIN_W'(req_cand_word) + LIN_W'(req_cand_tag);
    avail     = req_end - cur_lin;
    early_lit = !req_cand_valid || (cand_lin >= cur_lin) || (req_end <= cur_lin) ||
                (avail < LIN_W'(MIN_MATCH));
    lim_calc  = (avail >= LIN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : LEN_W'(avail);
  end

  // Bank storage and read addressing.
  logic [2:0][WORD_AW-1:0] cur_addr, cand_addr;
  logic [2:0][7:0]         bank_q;
  logic                    sel_cand, rd_en;

  assign sel_cand = (state_q == ST_RD_CAND) || (state_q == ST_LD_CUR);
  assign rd_en    = sel_cand || (state_q == ST_RD_CUR);

  tbm_addr_align #(.AW(WORD_AW)) u_cur_align (
    .clk(clk), .rst_n(rst_i_n), .load(accept), .load_word(req_cur_word),
    .step(step_s), .tag(cur_tag_q), .bank_addr(cur_addr)
  );

  tbm_addr_align #(.AW(WORD_AW)) u_cand_align (
    .clk(clk), .rst_n(rst_i_n), .load(accept), .load_word(req_cand_word),
    .step(step_s), .tag(cand_tag_q), .bank_addr(cand_addr)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    tbm_bank #(.AW(WORD_AW)) u_bank (
      .clk   (clk),
      .we    (wr_en && (wr_tag == 2'(b))),
      .waddr (wr_word),
      .wdata (wr_data),
      .re    (rd_en),
      .raddr (sel_cand ? cand_addr[b] : cur_addr[b]),
      .rdata (bank_q[b])
    );
  end

  // Combinational reorder and compare.
  logic [23:0] ordered;
  logic [1:0]  nmatch;

  tbm_compare u_cmp (
    .tag       ((state_q == ST_LD_CUR) ? cur_tag_q : cand_tag_q),
    .bank_q    (bank_q),
    .ref_bytes (ref_q),
    .ordered   (ordered),
    .nmatch    (nmatch)
  );

  // Next-state logic.
  logic [LEN_W-1:0] room, nm_w, take;

  assign accept = req_valid && req_ready;
  assign room   = lim_q - len_q;
  assign nm_w   = LEN_W'(nmatch);
  assign take   = (nm_w > room) ? room : nm_w;

  always_comb begin
    state_d     = state_q;
    cur_tag_d   = cur_tag_q;
    cand_tag_d  = cand_tag_q;
    cand_word_d = cand_word_q;
    ref_d       = ref_q;
    lim_d       = lim_q;
    copy_d      = copy_q;
    step_s      = 1'b0;
    len_clr     = 1'b0;
    len_inc_en  = 1'b0;
    len_inc     = '0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          cur_tag_d   = req_cur_tag;
          cand_tag_d  = req_cand_tag;
          cand_word_d = req_cand_word;
          ref_d       = req_cur_bytes;
          lim_d       = lim_calc;
          copy_d      = 1'b0;
          len_clr     = 1'b1;
          state_d     = early_lit ? ST_EMIT : ST_RD_CAND;
        end
      end
      ST_RD_CAND: state_d = ST_CMP;
      ST_CMP: begin
        if ((len_q == '0) && (nmatch != 2'd3)) begin
          copy_d  = 1'b0;
          state_d = ST_EMIT;
        end else begin
          copy_d     = 1'b1;
          len_inc_en = 1'b1;
          len_inc    = take;
          if ((nmatch == 2'd3) && (room > LEN_W'(3))) begin
            step_s  = 1'b1;
            state_d = ST_RD_CUR;
          end else begin
            state_d = ST_EMIT;
          end
        end
      end
      ST_RD_CUR: state_d = ST_LD_CUR;
      ST_LD_CUR: begin
        ref_d   = ordered;
        state_d = ST_CMP;
      end
      ST_EMIT: begin
        if (item_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q     <= ST_IDLE;
      cur_tag_q   <= '0;
      cand_tag_q  <= '0;
      cand_word_q <= '0;
      ref_q       <= '0;
      lim_q       <= '0;
      copy_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      cur_tag_q   <= cur_tag_d;
      cand_tag_q  <= cand_tag_d;
      cand_word_q <= cand_word_d;
      ref_q       <= ref_d;
      lim_q       <= lim_d;
      copy_q      <= copy_d;
    end
  end

  // Match-length counter, advanced by the compare-success count.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)        len_q <= '0;
    else if (len_clr)    len_q <= '0;
    else if (len_inc_en) len_q <= len_q + len_inc;
  end

  // Item outputs.
  assign req_ready     = (state_q == ST_IDLE);
  assign item_valid    = (state_q == ST_EMIT);
  assign item_copy     = copy_q;
  assign item_len_code = copy_q ? CODE_W'(len_q - LEN_W'(MIN_MATCH)) : '0;
  assign item_adv      = copy_q ? len_q : LEN_W'(1);
  assign item_off_word = copy_q ? cand_word_q : '0;
  assign item_off_tag  = copy_q ? cand_tag_q : '0;
endmodule

// File: rtl/tbm_checks.sv
module tbm_checks
  import tbm_pkg::*;
#(
  parameter int WORD_AW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [WORD_AW-1:0] req_cur_word,
  input logic [1:0]         req_cur_tag,
  input logic               req_cand_valid,
  input logic [WORD_AW+1:0] req_end,
  input logic               item_valid,
  input logic               item_ready,
  input logic               item_copy,
  input logic [CODE_W-1:0]  item_len_code,
  input logic [LEN_W-1:0]   item_adv,
  input logic [WORD_AW-1:0] item_off_word,
  input logic [1:0]         item_off_tag
);
  int room_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) room_q <= 0;
    else if (req_valid && req_ready)
      room_q <= int'(req_end) - (3 * int'(req_cur_word) + int'(req_cur_tag));
  end

  a_r5_literal_code: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid && !item_copy |-> item_adv == LEN_W'(1) && item_len_code == '0 &&
                                 item_off_word == '0 && item_off_tag == '0);

  a_r6_copy_code: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid && item_copy |-> int'(item_adv) >= MIN_MATCH && int'(item_adv) <= MAX_LEN &&
                                int'(item_adv) == int'(item_len_code) + MIN_MATCH);

  a_r7_within_room: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid && item_copy |-> int'(item_adv) <= room_q);

  a_r4_no_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_cand_valid |=> item_valid && !item_copy);

  a_r8_busy_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid |-> !req_ready);

  a_r9_item_hold: assert property (@(posedge clk) disable iff (!rst_n)
    item_valid && !item_ready |=> item_valid &&
      $stable({item_copy, item_len_code, item_adv, item_off_word, item_off_tag}));
endmodule

bind tribank_match_engine tbm_checks #(.WORD_AW(WORD_AW)) u_tbm_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cur_word(req_cur_word), .req_cur_tag(req_cur_tag), .req_cand_valid(req_cand_valid),
  .req_end(req_end), .item_valid(item_valid), .item_ready(item_ready), .item_copy(item_copy),
  .item_len_code(item_len_code), .item_adv(item_adv), .item_off_word(item_off_word),
  .item_off_tag(item_off_tag)
);

// File: tb/test_tribank_match_engine.sv
`timescale 1ns/1ps
module test_tribank_match_engine;
  localparam int WAW = 6;
  localparam int NB  = 3 * (1 << WAW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [WAW-1:0] wr_word = '0;
  logic [1:0] wr_tag = '0;
  logic [7:0] wr_data = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [WAW-1:0] req_cur_word = '0;
  logic [1:0] req_cur_tag = '0;
  logic [23:0] req_cur_bytes = '0;
  logic req_cand_valid = 1'b0;
  logic [WAW-1:0] req_cand_word = '0;
  logic [1:0] req_cand_tag = '0;
  logic [WAW+1:0] req_end = '0;
  logic item_valid;
  logic item_ready = 1'b1;
  logic item_copy;
  logic [3:0] item_len_code;
  logic [4:0] item_adv;
  logic [WAW-1:0] item_off_word;
  logic [1:0] item_off_tag;

  int checks = 0;
  int errors = 0;
  logic [7:0] hist [NB];

  always #10 clk = ~clk;

  tribank_match_engine #(.WORD_AW(WAW)) i_tribank_match_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_tag(wr_tag),
    .wr_data(wr_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_cur_word(req_cur_word), .req_cur_tag(req_cur_tag), .req_cur_bytes(req_cur_bytes),
    .req_cand_valid(req_cand_valid), .req_cand_word(req_cand_word),
    .req_cand_tag(req_cand_tag), .req_end(req_end), .item_valid(item_valid),
    .item_ready(item_ready), .item_copy(item_copy), .item_len_code(item_len_code),
    .item_adv(item_adv), .item_off_word(item_off_word), .item_off_tag(item_off_tag)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] hb(input int i);
    return (i >= 0 && i < NB) ? hist[i] : 8'h00;
  endfunction

  function automatic logic [23:0] mem3(input int p);
    return {hb(p + 2), hb(p + 1), hb(p)};
  endfunction

  // Byte-level model of the expected match length (0 means literal).
  function automatic int ref_len(input int cur, input int cand, input bit cv,
                                 input int endp, input logic [23:0] cb);
    int lim, n;
    logic [7:0] a;
    if (!cv || cand >= cur || endp - cur < 3) return 0;
    lim = (endp - cur > 18) ? 18 : endp - cur;
    n = 0;
    while (n < lim) begin
      a = (n < 3) ? cb[8*n +: 8] : hb(cur + n);
      if (hb(cand + n) != a) break;
      n++;
    end
    return (n < 3) ? 0 : n;
  endfunction

  task automatic put(input int pos, input logic [7:0] v);
    wr_en = 1'b1;
    wr_word = WAW'(pos / 3);
    wr_tag = 2'(pos % 3);
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    hist[pos] = v;
  endtask

  task automatic run(input int cur, input int cand, input bit cv, input int endp,
                     input logic [23:0] cb, input int hold, input bit junk, input string rq);
    int e, ecopy, ecode, eadv, eow, eot, n;
    logic [15:0] snap;
    e = ref_len(cur, cand, cv, endp, cb);
    ecopy = (e > 0) ? 1 : 0;
    ecode = (e > 0) ? e - 3 : 0;
    eadv  = (e > 0) ? e : 1;
    eow   = (e > 0) ? cand / 3 : 0;
    eot   = (e > 0) ? cand % 3 : 0;
    chk(req_ready == 1'b1, {rq, " R8 ready when idle"}, int'(req_ready), 1);
    req_valid = 1'b1;
    req_cur_word = WAW'(cur / 3);
    req_cur_tag = 2'(cur % 3);
    req_cur_bytes = cb;
    req_cand_valid = cv;
    req_cand_word = WAW'(cand / 3);
    req_cand_tag = 2'(cand % 3);
    req_end = (WAW + 2)'(endp);
    item_ready = (hold == 0);
    @(negedge clk);
    req_valid = 1'b0;
    if (junk && endp < NB) begin
      wr_en = 1'b1;
      wr_word = WAW'(endp / 3);
      wr_tag = 2'(endp % 3);
      wr_data = ~hist[endp];
    end
    n = 0;
    while (!item_valid && n < 300) begin
      @(negedge clk);
      wr_en = 1'b0;
      n++;
    end
    wr_en = 1'b0;
    chk(item_valid == 1'b1, {rq, " item produced"}, int'(item_valid), 1);
    chk(int'(item_copy) == ecopy, {rq, " kind"}, int'(item_copy), ecopy);
    chk(int'(item_len_code) == ecode, {rq, " length code"}, int'(item_len_code), ecode);
    chk(int'(item_adv) == eadv, {rq, " advance"}, int'(item_adv), eadv);
    chk(int'(item_off_word) == eow && int'(item_off_tag) == eot, {rq, " offset"},
        3 * int'(item_off_word) + int'(item_off_tag), 3 * eow + eot);
    if (hold > 0) begin
      snap = {3'b0, item_copy, item_len_code, item_adv, item_off_tag[0], 2'b0};
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(item_valid == 1'b1 && int'(item_adv) == eadv && int'(item_len_code) == ecode &&
            snap == {3'b0, item_copy, item_len_code, item_adv, item_off_tag[0], 2'b0},
            {rq, " R9 item held"}, int'(item_adv), eadv);
      end
      item_ready = 1'b1;
    end
    @(negedge clk);
    chk(item_valid == 1'b0 && req_ready == 1'b1, {rq, " R8 single item"}, int'(item_valid), 0);
    if (junk && endp < NB) put(endp, hist[endp]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    chk(item_valid == 1'b0, "R1 no item in reset", int'(item_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && item_valid == 1'b0, "R1 idle after reset", int'(item_valid), 0);

    // R2: fill the history through the write port.
    for (int i = 0; i < NB; i++) begin
      logic [7:0] v;
      if (i < 40 || ($urandom % 8) == 0) v = 8'h61 + 8'($urandom % 3);
      else v = hist[i - 29];
      put(i, v);
    end

    run(50, 20, 1'b0, NB, mem3(50), 0, 1'b0, "R4/R5 invalid candidate");
    run(50, 50, 1'b1, NB, mem3(50), 0, 1'b0, "R4 candidate not earlier");
    run(100, 71, 1'b1, 102, mem3(100), 0, 1'b0, "R4 short tail");

    for (int k = 0; k < 20; k++) put(140 + k, hist[111 + k]);
    run(140, 111, 1'b1, NB, mem3(140), 0, 1'b0, "R7 cap at 18");
    run(140, 111, 1'b1, NB, mem3(140), 3, 1'b0, "R9 stalled copy");
    run(140, 111, 1'b1, 147, mem3(140), 0, 1'b1, "R10 write beyond end");
    run(140, 111, 1'b1, 143, mem3(140), 0, 1'b0, "R7 end limit");

    for (int k = 0; k < 5; k++) put(170 + k, hist[30 + k]);
    put(175, hist[35] ^ 8'h01);
    run(170, 30, 1'b1, NB, mem3(170), 0, 1'b0, "R7 first mismatch");

    put(60, 8'h78); put(61, 8'h79); put(62, 8'h7a);
    put(90, 8'h78); put(91, 8'h79); put(92, 8'h71);
    run(90, 60, 1'b1, NB, mem3(90), 0, 1'b0, "R6 third byte differs");
    run(90, 60, 1'b1, NB, 24'h7a7978, 0, 1'b0, "R3 current bytes input");

    for (int i = 0; i < 160; i++) begin
      int cur, cand, endp, m;
      bit cv;
      cur = 3 + int'($urandom % 187);
      m = int'($urandom % 10);
      cv = (m != 9);
      if (m < 6 && cur >= 29) cand = cur - 29;
      else if (m < 9) cand = int'($urandom % cur);
      else cand = 0;
      endp = (($urandom % 4) == 0) ? cur + int'($urandom % 22) : NB;
      if (endp > NB) endp = NB;
      run(cur, cand, cv, endp, mem3(cur), (i % 13 == 0) ? 2 : 0, 1'b0, "R2/R6/R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule